// File: doc/BRIEF.md
# Floppy Drive-Select Control Register

This block is a small control and status register placed between a processor bus and a floppy disk controller chip. It answers at one bus address. A write to that address stores a control byte. The stored byte selects one of up to four drives and turns write precompensation on or off. It can also supply the density choice. The stored bits become the controller's active-low density-enable input, its precompensation-enable input and a set of active-low drive-select lines.

A static strap input picks where the density choice comes from: the controller's side-select output or bit 7 of the stored byte. In both cases the chosen source is inverted onto the active-low enable, so a 1 on the source asks for double density.

A read at the same address does not return the stored byte. It returns the controller's raw interrupt-request and data-request lines, each passed through a synchronizer first. A polling loop can then test a single bit without decoding the controller's own status register.

Top module: `fdc_sel_latch`

## Requirements
- R1: A synchronous active-high reset clears the stored byte. After reset, precompensation is off and no drive is selected. With the strap low, single density is selected (density enable high).
- R2: The stored byte loads from the write data on a clock edge where chip-select and write-strobe are high and the address equals the block's base address. At any other edge the stored byte keeps its value.
- R3: The precompensation-enable output equals bit 3 of the stored byte, whatever that byte's other bits and the selected drive are.
- R4: With the strap low, the active-low density-enable output is the inverse of bit 7 of the stored byte, and the side-select input has no effect on it.
- R5: With the strap high, the active-low density-enable output is the inverse of the side-select input, and bit 7 of the stored byte has no effect on it.
- R6: Bits 2..0 of the stored byte form a drive field. A value k from 1 to 4 drives the active-low select line k-1 low and leaves the others high. The values 0, 5, 6 and 7 leave every select line high.
- R7: While chip-select and read-strobe are high and the address matches, the read bus shows the synchronized active-low interrupt line on bit 7 and the synchronized active-low data-request line on bit 6. Bits 5..0 read as zero.
- R8: A change on the interrupt or data-request input shows on the read bus after exactly two clock edges. After reset, both synchronized lines read as 1 until the inputs have been sampled through.
- R9: When no matching read is in progress, the read bus is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cs_i | input | 1 | Chip-select |
| addr_i | input | ADDR_W | Bus address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, zero when not read |
| fdc_intrq_n_i | input | 1 | Controller interrupt request, active low |
| fdc_drq_n_i | input | 1 | Controller data request, active low |
| fdc_side_i | input | 1 | Controller side-select output |
| dens_strap_i | input | 1 | Density source strap: 1 selects side-select, 0 selects stored bit 7 |
| fdc_dden_n_o | output | 1 | Density enable to controller, active low |
| fdc_precomp_o | output | 1 | Write precompensation enable |
| drv_sel_n_o | output | NUM_DRIVES | Drive select lines, active low |

## Verification
The bench builds the block with its defaults: a 4-bit address with base 4, an 8-bit bus, four drives and two synchronizer stages. At these values every one of the 256 control bytes can be written and checked against all outputs under both strap settings. All four combinations of the interrupt and data-request lines can be stepped through while the read bus is checked one cycle and two cycles after each change. Writes with a wrong address, without chip-select and without the write strobe are mixed in to show that the stored byte holds.

// File: rtl/fdsel_pkg.sv
package fdsel_pkg;
   // Bit positions that software relies on.
   localparam int unsigned PRECOMP_BIT = 3;
   localparam int unsigned DENS_BIT    = 7;
   localparam int unsigned IRQ_RD_BIT  = 7;
   localparam int unsigned DRQ_RD_BIT  = 6;
   localparam int unsigned MIN_DATA_W  = 8;
endpackage

// File: rtl/fdsel_sync.sv
module fdsel_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fdsel_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= {STAGES{RST_VAL}};
      else       chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fdsel_drv_dec.sv
module fdsel_drv_dec #(
   parameter int unsigned SEL_W      = 3,
   parameter int unsigned NUM_DRIVES = 4
) (
   input  logic [SEL_W-1:0]      field_i,
   output logic [NUM_DRIVES-1:0] sel_n_o
);
   generate
      if (NUM_DRIVES > (2**SEL_W) - 1) begin : g_bad_width
         $error("fdsel_drv_dec: drive field too narrow for NUM_DRIVES");
      end
      // Field value k selects drive k-1; zero selects none.
      for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
         localparam logic [SEL_W-1:0] CODE = SEL_W'(d + 1);
         assign sel_n_o[d] = (field_i != CODE);
      end
   endgenerate
endmodule

// File: rtl/fdc_sel_latch.sv
module fdc_sel_latch
   import fdsel_pkg::*;
#(
   parameter int unsigned     ADDR_W      = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 4'h4,
   parameter int unsigned     DATA_W      = 8,
   parameter int unsigned     NUM_DRIVES  = 4,
   parameter int unsigned     SEL_W       = 3,
   parameter int unsigned     SYNC_STAGES = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  cs_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic                  wr_i,
   input  logic                  rd_i,
   input  logic [DATA_W-1:0]     wdata_i,
   output logic [DATA_W-1:0]     rdata_o,
   input  logic                  fdc_intrq_n_i,
   input  logic                  fdc_drq_n_i,
   input  logic                  fdc_side_i,
   input  logic                  dens_strap_i,
   output logic                  fdc_dden_n_o,
   output logic                  fdc_precomp_o,
   output logic [NUM_DRIVES-1:0] drv_sel_n_o
);
   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
         $error("fdc_sel_latch: DATA_W must be at least 8");
      end
      if (SEL_W > PRECOMP_BIT) begin : g_bad_sel_w
         $error("fdc_sel_latch: drive field overlaps precompensation bit");
      end
   endgenerate

   localparam int unsigned LOW_ZERO_W = DRQ_RD_BIT;

   logic              addr_hit;
   logic              wr_hit;
   logic              rd_hit;
   logic [DATA_W-1:0] ctrl_q;
   logic              irq_sync;
   logic              drq_sync;
   logic              dens_src;
   logic              unused_ctrl;

   assign addr_hit = cs_i && (addr_i == BASE_ADDR);
   assign wr_hit   = addr_hit && wr_i;
   assign rd_hit   = addr_hit && rd_i;

   always_ff @(posedge clk_i) begin
      if (rst_i)       ctrl_q <= '0;
      else if (wr_hit) ctrl_q <= wdata_i;
   end

   assign unused_ctrl = ^ctrl_q;

   // Drive-select field decode
   fdsel_drv_dec #(
      .SEL_W     (SEL_W),
      .NUM_DRIVES(NUM_DRIVES)
   ) u_dec (
      .field_i(ctrl_q[SEL_W-1:0]),
      .sel_n_o(drv_sel_n_o)
   );

   // Density source: strap picks side-select pin or stored bit, then inverted
   assign dens_src      = dens_strap_i ? fdc_side_i : ctrl_q[DENS_BIT];
   assign fdc_dden_n_o  = ~dens_src;
   assign fdc_precomp_o = ctrl_q[PRECOMP_BIT];

   // Status line synchronizers, idle-high after reset
   fdsel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_irq_sync (
      .clk_i(clk_i), .rst_i(rst_i), .d_i(fdc_intrq_n_i), .q_o(irq_sync)
   );
   fdsel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_drq_sync (
      .clk_i(clk_i), .rst_i(rst_i), .d_i(fdc_drq_n_i), .q_o(drq_sync)
   );

   always_comb begin
      rdata_o = '0;
      if (rd_hit) begin
         rdata_o[IRQ_RD_BIT]       = irq_sync;
         rdata_o[DRQ_RD_BIT]       = drq_sync;
         rdata_o[LOW_ZERO_W-1:0]   = '0;
      end
   end
endmodule

// File: rtl/fdc_sel_latch_chk.sv
module fdc_sel_latch_chk
   import fdsel_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR  = 4'h4,
   parameter int unsigned       DATA_W     = 8,
   parameter int unsigned       NUM_DRIVES = 4
) (
   input logic                  clk_i,
   input logic                  rst_i,
   input logic                  cs_i,
   input logic [ADDR_W-1:0]     addr_i,
   input logic                  wr_i,
   input logic                  rd_i,
   input logic [DATA_W-1:0]     wdata_i,
   input logic [DATA_W-1:0]     rdata_o,
   input logic                  fdc_intrq_n_i,
   input logic                  fdc_drq_n_i,
   input logic                  dens_strap_i,
   input logic                  fdc_dden_n_o,
   input logic                  fdc_precomp_o,
   input logic [NUM_DRIVES-1:0] drv_sel_n_o
);
   logic [1:0] live_cnt;
   logic       wr_go;
   logic       rd_go;

   assign wr_go = cs_i && wr_i && (addr_i == BASE_ADDR);
   assign rd_go = cs_i && rd_i && (addr_i == BASE_ADDR);

   always_ff @(posedge clk_i) begin
      if (rst_i)              live_cnt <= '0;
      else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
   end

   // R1: reset leaves precompensation off and no drive selected
   a_r1_reset_clear: assert property (@(posedge clk_i)
      rst_i |=> (!fdc_precomp_o && (&drv_sel_n_o)));

   // R2: without a matching write the control outputs hold
   a_r2_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      !wr_go |=> ($stable(fdc_precomp_o) && $stable(drv_sel_n_o)));

   // R3: precompensation follows written bit 3
   a_r3_precomp: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_go |=> (fdc_precomp_o == $past(wdata_i[PRECOMP_BIT])));

   // R4: with the strap low the written bit 7 sets density, inverted
   a_r4_dens_latch: assert property (@(posedge clk_i) disable iff (rst_i)
      (wr_go && !dens_strap_i) ##1 !dens_strap_i |->
         (fdc_dden_n_o == !$past(wdata_i[DENS_BIT])));

   // R6: never more than one drive selected
   a_r6_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(~drv_sel_n_o));

   // R7: low read bits stay zero
   a_r7_low_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      rdata_o[DRQ_RD_BIT-1:0] == '0);

   // R8: status reaches the read bus two edges after sampling
   a_r8_latency: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_go && live_cnt == 2'd3) |->
         (rdata_o[IRQ_RD_BIT] == $past(fdc_intrq_n_i, 2) &&
          rdata_o[DRQ_RD_BIT] == $past(fdc_drq_n_i, 2)));

   // R9: read bus idles at zero
   a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
      !rd_go |-> (rdata_o == '0));
endmodule

bind fdc_sel_latch fdc_sel_latch_chk #(
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR),
   .DATA_W    (DATA_W),
   .NUM_DRIVES(NUM_DRIVES)
) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .cs_i         (cs_i),
   .addr_i       (addr_i),
   .wr_i         (wr_i),
   .rd_i         (rd_i),
   .wdata_i      (wdata_i),
   .rdata_o      (rdata_o),
   .fdc_intrq_n_i(fdc_intrq_n_i),
   .fdc_drq_n_i  (fdc_drq_n_i),
   .dens_strap_i (dens_strap_i),
   .fdc_dden_n_o (fdc_dden_n_o),
   .fdc_precomp_o(fdc_precomp_o),
   .drv_sel_n_o  (drv_sel_n_o)
);

// File: tb/fdc_sel_latch_tb_top.sv
module fdc_sel_latch_tb_top;
   localparam int ADDR_W = 4;
   localparam logic [3:0] BASE = 4'h4;

   logic       clk_i = 1'b0;
   logic       rst_i = 1'b1;
   logic       cs_i = 1'b0;
   logic [3:0] addr_i = '0;
   logic       wr_i = 1'b0;
   logic       rd_i = 1'b0;
   logic [7:0] wdata_i = '0;
   logic [7:0] rdata_o;
   logic       fdc_intrq_n_i = 1'b1;
   logic       fdc_drq_n_i = 1'b1;
   logic       fdc_side_i = 1'b0;
   logic       dens_strap_i = 1'b0;
   logic       fdc_dden_n_o;
   logic       fdc_precomp_o;
   logic [3:0] drv_sel_n_o;

   int total = 0;
   int bad = 0;

   always #10 clk_i = ~clk_i;

   fdc_sel_latch dut_i (.*);

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_drv(input logic [7:0] v);
      int k = int'(v[2:0]);
      if (k >= 1 && k <= 4) return ~(4'b0001 << (k - 1));
      return 4'hF;
   endfunction

   task automatic bus_write(input logic [3:0] a, input logic c, input logic w, input logic [7:0] d);
      @(negedge clk_i);
      cs_i = c; addr_i = a; wr_i = w; wdata_i = d;
      @(posedge clk_i);
      @(negedge clk_i);
      cs_i = 1'b0; wr_i = 1'b0; addr_i = '0;
   endtask

   task automatic check_ctrl(input string tag, input logic [7:0] v);
      chk({tag, " R3 precomp"}, {7'd0, fdc_precomp_o}, {7'd0, v[3]});
      chk({tag, " R6 drive"}, {4'd0, drv_sel_n_o}, {4'd0, exp_drv(v)});
   endtask

   task automatic rd_on();
      cs_i = 1'b1; addr_i = BASE; rd_i = 1'b1;
   endtask
   task automatic rd_off();
      cs_i = 1'b0; addr_i = '0; rd_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk_i);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      logic [7:0] held;
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      rst_i = 1'b0;
      // R1 reset state
      chk("R1 precomp", {7'd0, fdc_precomp_o}, 8'd0);
      chk("R1 drives", {4'd0, drv_sel_n_o}, 8'h0F);
      chk("R1 dden_n", {7'd0, fdc_dden_n_o}, 8'd1);
      // R9 idle read bus
      chk("R9 idle", rdata_o, 8'h00);
      rd_on(); #1;
      chk("R8 reset readback", rdata_o, 8'hC0);
      rd_off();

      // Sweep all control bytes, strap low (R2..R6)
      for (int v = 0; v < 256; v++) begin
         bus_write(BASE, 1'b1, 1'b1, 8'(v));
         fdc_side_i = ~v[7]; #1;
         check_ctrl("sweep", 8'(v));
         chk("R4 dden from bit7", {7'd0, fdc_dden_n_o}, {7'd0, ~v[7]});
         fdc_side_i = v[7]; #1;
         chk("R4 side ignored", {7'd0, fdc_dden_n_o}, {7'd0, ~v[7]});
         chk("R9 idle after write", rdata_o, 8'h00);
      end

      // R5 strap high: side drives density, bit 7 ignored
      dens_strap_i = 1'b1;
      for (int b = 0; b < 2; b++) begin
         bus_write(BASE, 1'b1, 1'b1, b[0] ? 8'h80 : 8'h00);
         for (int s = 0; s < 2; s++) begin
            fdc_side_i = s[0]; #1;
            chk("R5 dden from side", {7'd0, fdc_dden_n_o}, {7'd0, ~s[0]});
         end
      end
      dens_strap_i = 1'b0;

      // R2 non-matching writes keep the stored byte
      held = 8'h8B;
      bus_write(BASE, 1'b1, 1'b1, held);
      bus_write(BASE + 4'd1, 1'b1, 1'b1, 8'h01);
      check_ctrl("R2 wrong addr", held);
      bus_write(BASE, 1'b0, 1'b1, 8'h02);
      check_ctrl("R2 no cs", held);
      bus_write(BASE, 1'b1, 1'b0, 8'h03);
      check_ctrl("R2 no wr", held);
      chk("R2 dden held", {7'd0, fdc_dden_n_o}, 8'd0);

      // R7/R8 readback of all status combinations with latency
      for (int p = 0; p < 4; p++) begin
         logic [1:0] prev;
         prev = {fdc_intrq_n_i, fdc_drq_n_i};
         @(negedge clk_i);
         fdc_intrq_n_i = p[1]; fdc_drq_n_i = p[0];
         @(negedge clk_i);
         rd_on(); #1;
         chk("R8 one edge old", rdata_o, {prev, 6'd0});
         @(negedge clk_i); #1;
         chk("R7 status readback", rdata_o, {p[1], p[0], 6'd0});
         addr_i = BASE + 4'd2; #1;
         chk("R9 wrong addr read", rdata_o, 8'h00);
         rd_off(); #1;
         chk("R9 idle", rdata_o, 8'h00);
      end

      // R1 reset from a loaded state
      bus_write(BASE, 1'b1, 1'b1, 8'h8A);
      @(negedge clk_i); rst_i = 1'b1;
      @(negedge clk_i); rst_i = 1'b0;
      check_ctrl("R1 after reset", 8'h00);
      chk("R1 dden_n after reset", {7'd0, fdc_dden_n_o}, 8'd1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule